// File: doc/BRIEF.md
# Function-Unit Dependency Matrix

This block tracks hazards between the operations that are in flight across a set of function units. It holds a square array of single-bit latches, with one row and one column per unit. The bit at row `u`, column `v` records that unit `u` must wait for unit `v`. Two such arrays are kept. The read array holds read-after-write waits and gates the grant to read operands. The write array holds write-after-write waits and ordering waits, and gates the grant to commit.

Each row also holds a write-prevention flag. It is used for operations that could still fault, and for operations issued down a speculated path. A unit may be granted its operand read and start work while its commit is still withheld. Its result then waits in the unit until the write grant arrives.

A kill vector flushes wrongly speculated units. It clears the killed units' rows and columns and returns those units to idle. When a unit reports that its write is done, its column is erased from every row, which releases everything that waited on it. Load and store units sit in ordinary rows like any other unit. The block does no execution and holds no operand data.

Top module: `fu_dep_matrix`

## Requirements
- R1: After reset every unit is idle. `busy`, `go_read` and `go_write` are all zero.
- R2: An issue to an idle unit loads that unit's read-wait and write-wait rows from `issue_raw` and `issue_waw`. Bits that name the unit itself, an idle unit, or a unit being cleared in the same cycle are dropped. An issue addressed to a unit that is already busy is ignored and leaves that unit's state unchanged.
- R3: `go_read[u]` is high for exactly one cycle, the first cycle in which unit `u` is busy and its read-wait row is all zero. This is the cycle after the issue edge when the unit has no waits.
- R4: A unit is eligible for `go_write` only if all of these hold: it has had its read grant, both of its rows are all zero, its write-prevention flag is clear, and it has not yet been granted a write.
- R5: A unit issued with `issue_wprev` set receives no `go_write` until a `rel_vec` bit for that unit clears the flag. The grant can then appear in the cycle after the release edge.
- R6: A completion (`comp_valid` with `comp_unit`) returns that unit to idle and clears its column in every row at the same edge. Units that waited only on it receive their grants in the following cycle.
- R7: A set bit in `die_vec` returns that unit to idle and clears its row and column at the same edge. A killed unit receives no later `go_write`.
- R8: At most one `go_write` bit is high in any cycle. When several units are eligible, the grant goes to the one with the lowest index.
- R9: Naming all older busy units in `issue_waw` makes commits follow issue order rather than index order.
- R10: A unit that waits only through its write-wait row still receives `go_read` at once. Only its commit is held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue strobe |
| issue_unit | input | IW | Index of the unit being issued |
| issue_raw | input | N | Units whose results the new operation reads |
| issue_waw | input | N | Units that must commit before the new operation |
| issue_wprev | input | 1 | Start the new operation under write-prevention |
| rel_vec | input | N | Clear write-prevention for the marked units |
| comp_valid | input | 1 | Completion strobe |
| comp_unit | input | IW | Index of the unit that finished its write |
| die_vec | input | N | Kill the marked units |
| busy | output | N | Unit holds an operation |
| go_read | output | N | Operand read grant, one pulse per operation |
| go_write | output | N | Commit grant, one pulse per operation |

## Verification
The assertions take several things for granted about the inputs. A completion arrives only for a unit that has already had its write grant and has not yet completed. A unit is killed only while its write-prevention flag holds off its write grant. A release targets only a busy unit. The stimulus keeps to these rules: each completion is driven in the cycle when its grant is visible, kills are applied only to held units, and releases are applied only to units the bench has issued. Under these conditions the checks cover grant pulses, write-prevention, one-hot selection and clearing on completion.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  parameter int unsigned FDM_UNITS = 8;

  typedef struct packed {
    logic busy;
    logic rd_done;
    logic wr_done;
    logic wprev;
  } fdm_state_t;
endpackage

// File: rtl/fdm_row.sv
module fdm_row #(
  parameter int N   = fdm_pkg::FDM_UNITS,
  parameter int IDX = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue_me,
  input  logic [N-1:0] dep_raw,
  input  logic [N-1:0] dep_waw,
  input  logic         issue_wprev,
  input  logic [N-1:0] col_clr,
  input  logic         rel_me,
  input  logic         rd_take,
  input  logic         wr_take,
  output fdm_pkg::fdm_state_t st,
  output logic         raw_any,
  output logic         waw_any
);
  logic [N-1:0] raw_q, waw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      raw_q <= '0;
      waw_q <= '0;
    end else if (col_clr[IDX]) begin
      st    <= '0;
      raw_q <= '0;
      waw_q <= '0;
    end else if (issue_me && !st.busy) begin
      st.busy    <= 1'b1;
      st.rd_done <= 1'b0;
      st.wr_done <= 1'b0;
      st.wprev   <= issue_wprev;
      raw_q      <= dep_raw;
      waw_q      <= dep_waw;
    end else begin
      raw_q <= raw_q & ~col_clr;
      waw_q <= waw_q & ~col_clr;
      if (rd_take) st.rd_done <= 1'b1;
      if (wr_take) st.wr_done <= 1'b1;
      if (rel_me)  st.wprev   <= 1'b0;
    end
  end

  assign raw_any = |raw_q;
  assign waw_any = |waw_q;

  // R3: read grant lasts one cycle per operation
  a_r3_read_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> !rd_take);
  // R4: commit only after read and with no waits pending
  a_r4_write_ready: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (st.rd_done && raw_q == '0 && waw_q == '0));
  // R5: write-prevention withholds the commit grant
  a_r5_wprev_hold: assert property (@(posedge clk) disable iff (rst)
    st.wprev |-> !wr_take);
  // R6 / R7: clearing a unit leaves it idle with no further grant
  a_r6_clear_idle: assert property (@(posedge clk) disable iff (rst)
    col_clr[IDX] |=> (!st.busy && !wr_take));
endmodule

// File: rtl/fdm_pick.sv
module fdm_pick #(
  parameter int N = fdm_pkg::FDM_UNITS
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
  parameter int N = fdm_pkg::FDM_UNITS,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [IW-1:0] issue_unit,
  input  logic [N-1:0]  issue_raw,
  input  logic [N-1:0]  issue_waw,
  input  logic          issue_wprev,
  input  logic [N-1:0]  rel_vec,
  input  logic          comp_valid,
  input  logic [IW-1:0] comp_unit,
  input  logic [N-1:0]  die_vec,
  output logic [N-1:0]  busy,
  output logic [N-1:0]  go_read,
  output logic [N-1:0]  go_write
);
  logic [N-1:0] iss_oh, comp_oh, col_clr, dep_mask;
  logic [N-1:0] raw_any, waw_any, elig;
  fdm_pkg::fdm_state_t st [N];

  assign iss_oh   = issue_valid ? (N'(1) << issue_unit) : '0;
  assign comp_oh  = comp_valid  ? (N'(1) << comp_unit)  : '0;
  assign col_clr  = comp_oh | die_vec;
  assign dep_mask = busy & ~col_clr & ~iss_oh;

  for (genvar g = 0; g < N; g++) begin : g_row
    fdm_row #(.N(N), .IDX(g)) u_row (
      .clk         (clk),
      .rst         (rst),
      .issue_me    (iss_oh[g]),
      .dep_raw     (issue_raw & dep_mask),
      .dep_waw     (issue_waw & dep_mask),
      .issue_wprev (issue_wprev),
      .col_clr     (col_clr),
      .rel_me      (rel_vec[g]),
      .rd_take     (go_read[g]),
      .wr_take     (go_write[g]),
      .st          (st[g]),
      .raw_any     (raw_any[g]),
      .waw_any     (waw_any[g])
    );
    assign busy[g]    = st[g].busy;
    assign go_read[g] = st[g].busy && !st[g].rd_done && !raw_any[g];
    assign elig[g]    = st[g].busy && st[g].rd_done && !st[g].wr_done &&
                        !st[g].wprev && !raw_any[g] && !waw_any[g];
  end

  fdm_pick #(.N(N)) u_pick (
    .req (elig),
    .gnt (go_write)
  );

  // R8: no more than one commit grant per cycle
  a_r8_one_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(go_write));
  // R1: grants stay low while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ((go_read | go_write) & ~busy) == '0);
endmodule

// File: tb/tb_fu_dep_matrix.sv
`timescale 1ns/1ps
module tb_fu_dep_matrix;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          issue_valid;
  logic [IW-1:0] issue_unit;
  logic [N-1:0]  issue_raw, issue_waw;
  logic          issue_wprev;
  logic [N-1:0]  rel_vec;
  logic          comp_valid;
  logic [IW-1:0] comp_unit;
  logic [N-1:0]  die_vec;
  logic [N-1:0]  busy, go_read, go_write;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fu_dep_matrix #(.N(N)) dut (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_unit(issue_unit),
    .issue_raw(issue_raw), .issue_waw(issue_waw), .issue_wprev(issue_wprev),
    .rel_vec(rel_vec), .comp_valid(comp_valid), .comp_unit(comp_unit),
    .die_vec(die_vec), .busy(busy), .go_read(go_read), .go_write(go_write)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle_in();
    issue_valid = 0; issue_unit = '0; issue_raw = '0; issue_waw = '0;
    issue_wprev = 0; rel_vec = '0; comp_valid = 0; comp_unit = '0; die_vec = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    idle_in();
  endtask

  task automatic do_reset();
    idle_in();
    rst = 1;
    cyc(); cyc();
    rst = 0;
  endtask

  task automatic iss(input int u, input logic [N-1:0] r, input logic [N-1:0] w, input logic wp);
    issue_valid = 1; issue_unit = IW'(u); issue_raw = r; issue_waw = w; issue_wprev = wp;
  endtask

  task automatic comp(input int u);
    comp_valid = 1; comp_unit = IW'(u);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1;
    do_reset();
    // R1 reset state
    chk("R1 busy", busy, '0);
    chk("R1 go_read", go_read, '0);
    chk("R1 go_write", go_write, '0);

    // Pair sweep: b depends on a through the read row (kind 0) or write row (kind 1)
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        for (int kind = 0; kind < 2; kind++) begin
          if (a == b) continue;
          do_reset();
          iss(a, '0, '0, 0); cyc();
          chk("R3 first read", go_read, N'(1) << a);
          iss(b, kind == 0 ? N'(1) << a : '0, kind == 1 ? N'(1) << a : '0, 0); cyc();
          chk("R4 write of a", go_write, N'(1) << a);
          if (kind == 0) chk("R2 raw blocks read", go_read, '0);
          else           chk("R10 read despite waw", go_read, N'(1) << b);
          comp(a); cyc();
          if (kind == 0) chk("R6 read after completion", go_read, N'(1) << b);
          else           chk("R6 write after completion", go_write, N'(1) << b);
        end
      end
    end

    // R2: bits naming self or an idle unit are dropped
    do_reset();
    iss(0, 8'h11, 8'h11, 0); cyc();
    chk("R2 self/idle dropped", go_read, 8'h01);
    cyc();
    chk("R2 self/idle dropped write", go_write, 8'h01);

    // R2: issue to a busy unit is ignored
    do_reset();
    iss(3, '0, '0, 1); cyc(); cyc();
    iss(3, '0, '0, 0); cyc();
    chk("R2 busy reissue no read", go_read, '0);
    chk("R2 busy reissue keeps hold", go_write, '0);
    cyc();
    chk("R2 busy reissue still held", go_write, '0);

    // R5 and R8: held units released together, lowest index first
    do_reset();
    iss(6, '0, '0, 1); cyc();
    iss(1, '0, '0, 1); cyc();
    iss(4, '0, '0, 1); cyc();
    cyc();
    chk("R5 held no write", go_write, '0);
    chk("R5 busy set", busy, 8'h52);
    rel_vec = 8'h52; cyc();
    chk("R8 lowest first", go_write, 8'h02);
    comp(1); cyc();
    chk("R8 next lowest", go_write, 8'h10);
    comp(4); cyc();
    chk("R8 last", go_write, 8'h40);
    comp(6); cyc();
    chk("R6 all idle", busy, '0);

    // R7: kill releases dependent, killed unit never commits
    do_reset();
    iss(2, '0, '0, 1); cyc();
    iss(5, 8'h04, '0, 0); cyc();
    chk("R7 busy before kill", busy, 8'h24);
    chk("R7 dependent waits", go_read, '0);
    die_vec = 8'h04; cyc();
    chk("R7 killed idle", busy, 8'h20);
    chk("R7 dependent reads", go_read, 8'h20);
    chk("R7 no write yet", go_write, '0);
    cyc();
    chk("R7 survivor commits", go_write, 8'h20);

    // R9: issue-order commit via write-wait row
    do_reset();
    iss(7, '0, '0, 1); cyc();
    iss(5, '0, 8'h80, 0); cyc();
    iss(2, '0, 8'hA0, 0); cyc();
    cyc();
    chk("R9 all held", go_write, '0);
    rel_vec = 8'h80; cyc();
    chk("R9 oldest first", go_write, 8'h80);
    comp(7); cyc();
    chk("R9 second oldest", go_write, 8'h20);
    comp(5); cyc();
    chk("R9 youngest", go_write, 8'h04);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule